// File: doc/BRIEF.md
# Per-Core Private Countdown Timer

A down-counting timer that gives one processor core a private source of local interrupts. Software programs it through a small word-addressed register port. A load value sets the reload point, a control word picks the run mode and the clock divide, and a sticky event flag records each expiry. The event flag drives a level interrupt output through an enable bit. Software acknowledges the interrupt by writing a one to the flag.

The timer has two modes. In one-shot mode it stops at zero. In auto-reload mode the counter returns to the load value one tick after it reaches zero. An 8-bit prescaler stretches every count step to (prescaler + 1) input clock cycles. Writes of zero to the load or counter registers follow their own stop and reload rules, which depend on the mode and on the prescaler value, so that software can halt the timer cleanly without a spurious event.

Top module: `cpu_local_timer`

## Requirements
- R1: After reset the load, counter, control and status registers all read zero, the interrupt output is low and the counter does not move.
- R2: Register offsets are 0x00 load, 0x04 counter, 0x08 control and 0x0C status. Control bit 0 is enable, bit 1 is auto-reload, bit 2 is interrupt enable and bits 15:8 are the prescaler; other control bits read as zero. Every other offset in the 0x20 window reads zero and ignores writes.
- R3: While running, the counter steps down once every (prescaler + 1) clock cycles. Any write to load, counter or control restarts the divider, so the first step comes (prescaler + 1) cycles after that write.
- R4: In one-shot mode, reaching zero sets the event flag and stops the counter at zero.
- R5: In auto-reload mode, reaching zero sets the event flag and the next tick loads the counter with the load value.
- R6: The interrupt output is high exactly when the event flag is set and control bit 2 is set. A status write with bit 0 set clears the flag, and a status write with bit 0 clear leaves it unchanged. A write to load, counter or control takes priority over a tick in the same cycle.
- R7: A load write sets both the load and counter values. If the timer is enabled with prescaler 0 and the value written is 0, the timer stops without an event.
- R8: With the timer enabled and prescaler 0, a counter write of 0 stops the timer without an event in one-shot mode, and also in auto-reload mode when the load value is 0. In auto-reload mode with a nonzero load value, the same write loads the counter with the load value and counting goes on.
- R9: A control write that sets enable and auto-reload with prescaler 0 while the counter is 0 first reloads the counter from the load value. The timer then runs whenever it is enabled and either the prescaler or the counter is nonzero.
- R10: In auto-reload mode with load 0, the timer stops after one event when the prescaler is 0. With a nonzero prescaler it raises an event on every tick.
- R11: Clearing the enable bit freezes the counter at its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| addr | input | 5 | Byte offset within the 0x20 register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` (combinational) |
| irq | output | 1 | Level interrupt, event flag gated by the interrupt enable |

## Verification
The bench targets the zero-value corners.

- Load 0 written while running must stop the timer quietly. A design that treated it as a normal load would raise a spurious event.
- Counter 0 written in auto-reload mode must reload the counter. A design that stopped instead would lose the periodic interrupt.
- Counter 0 written in one-shot mode must stop the timer. A design that ran on would wrap to all ones.
- Auto-reload with load 0 and prescaler 0 must yield exactly one event. A design that got this wrong would fire on every cycle.
- With load 0 and a nonzero prescaler, auto-reload must keep firing. A design that stopped would fire once.

The bench also measures the reload-after-one-tick timing, where an off-by-one design reloads on the zero tick itself. It checks the prescaler step period, where an off-by-one design steps every P cycles. Finally it checks that the interrupt enable masks the output without clearing the flag.

// File: rtl/cpu_local_timer.sv
module cpu_local_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08, A_STS = 5'h0C;

  logic [CNT_W-1:0] load_q, cnt_q, wval, ctl_cnt;
  logic [PRE_W-1:0] pre_q, div_q, wpre;
  logic en_q, per_q, ie_q, flag_q, run_q;
  logic wr_load, wr_cnt, wr_ctl, wr_sts, reg_wr, tick, expire, cnt_reload;

  assign wval    = wdata[CNT_W-1:0];
  assign wpre    = wdata[8 +: PRE_W];
  assign wr_load = wr_en && addr == A_LOAD;
  assign wr_cnt  = wr_en && addr == A_CNT;
  assign wr_ctl  = wr_en && addr == A_CTL;
  assign wr_sts  = wr_en && addr == A_STS;
  assign reg_wr  = wr_load || wr_cnt || wr_ctl;
  assign tick    = run_q && div_q == pre_q;
  assign expire  = tick && !reg_wr &&
                   (cnt_q == CNT_W'(1) || (cnt_q == '0 && (!per_q || load_q == '0)));
  assign cnt_reload = en_q && per_q && pre_q == '0 && wval == '0 && load_q != '0;
  assign ctl_cnt = (wdata[1] && wpre == '0 && cnt_q == '0) ? load_q : cnt_q;
  assign irq     = flag_q && ie_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_LOAD: rdata[CNT_W-1:0] = load_q;
      A_CNT:  rdata[CNT_W-1:0] = cnt_q;
      A_CTL:  begin
        rdata[8 +: PRE_W] = pre_q;
        rdata[2:0] = {ie_q, per_q, en_q};
      end
      A_STS:  rdata[0] = flag_q;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0; cnt_q <= '0; pre_q <= '0; div_q <= '0;
      en_q <= 1'b0; per_q <= 1'b0; ie_q <= 1'b0; flag_q <= 1'b0; run_q <= 1'b0;
    end else begin
      flag_q <= (flag_q && !(wr_sts && wdata[0])) || expire;
      if (reg_wr) div_q <= '0;
      else if (tick) div_q <= '0;
      else if (run_q) div_q <= div_q + PRE_W'(1);

      if (wr_load) begin
        load_q <= wval;
        cnt_q  <= wval;
        run_q  <= en_q && (pre_q != '0 || wval != '0);
      end else if (wr_cnt) begin
        if (cnt_reload) begin
          cnt_q <= load_q;
          run_q <= 1'b1;
        end else begin
          cnt_q <= wval;
          run_q <= en_q && (pre_q != '0 || wval != '0);
        end
      end else if (wr_ctl) begin
        en_q  <= wdata[0];
        per_q <= wdata[1];
        ie_q  <= wdata[2];
        pre_q <= wpre;
        if (wdata[0]) cnt_q <= ctl_cnt;
        run_q <= wdata[0] && (wpre != '0 || ctl_cnt != '0);
      end else if (tick) begin
        if (cnt_q > CNT_W'(1)) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (cnt_q == CNT_W'(1)) begin
          cnt_q <= '0;
          if (!per_q || (load_q == '0 && pre_q == '0)) run_q <= 1'b0;
        end else if (per_q) begin
          cnt_q <= load_q;
        end else begin
          run_q <= 1'b0;
        end
      end
    end
  end
endmodule

module cpu_local_timer_chk #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic [31:0]      wdata,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic [PRE_W-1:0] pre_q,
  input logic             en_q,
  input logic             per_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic             run_q,
  input logic             tick
);
  logic reg_wr;
  assign reg_wr = wr_en && (addr == 5'h00 || addr == 5'h04 || addr == 5'h08);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && tick && per_q && cnt_q == '0) |=> cnt_q == $past(load_q));
  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h0C && wdata[0] && !tick) |=> !flag_q);
  // R7
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h00 && wdata == '0 && en_q && pre_q == '0) |=> (!run_q && flag_q == $past(flag_q)));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_wr) |=> $stable(cnt_q));
endmodule

bind cpu_local_timer cpu_local_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .cnt_q(cnt_q), .load_q(load_q), .pre_q(pre_q), .en_q(en_q), .per_q(per_q),
  .ie_q(ie_q), .flag_q(flag_q), .run_q(run_q), .tick(tick)
);

// File: tb/cpu_local_timer_tb.sv
module cpu_local_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_local_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic prep(input logic [31:0] ld);
    wr(5'h08, 32'h0);
    wr(5'h00, ld);
    wr(5'h0C, 32'h1);
  endtask

  task automatic t_reset;
    chk_reg("R1 load", 5'h00, 0);
    chk_reg("R1 count", 5'h04, 0);
    chk_reg("R1 ctrl", 5'h08, 0);
    chk_reg("R1 status", 5'h0C, 0);
    chk("R1 irq", irq, 0);
    wait_n(3);
    chk_reg("R1 count still", 5'h04, 0);
  endtask

  task automatic t_oneshot;
    wr(5'h08, 32'h5);
    wr(5'h00, 32'd5);
    wait_n(4);
    chk_reg("R4 count before zero", 5'h04, 1);
    chk_reg("R4 no early event", 5'h0C, 0);
    wait_n(1);
    chk_reg("R4 count zero", 5'h04, 0);
    chk_reg("R4 event", 5'h0C, 1);
    chk("R6 irq high", irq, 1);
    wait_n(3);
    chk_reg("R4 stopped at zero", 5'h04, 0);
  endtask

  task automatic t_irq;
    wr(5'h08, 32'h1);
    chk("R6 irq masked", irq, 0);
    chk_reg("R6 flag kept", 5'h0C, 1);
    wr(5'h08, 32'h5);
    chk("R6 irq unmasked", irq, 1);
    wr(5'h0C, 32'h0);
    chk_reg("R6 write 0 keeps flag", 5'h0C, 1);
    wr(5'h0C, 32'h1);
    chk_reg("R6 write 1 clears", 5'h0C, 0);
    chk("R6 irq low", irq, 0);
  endtask

  task automatic t_periodic;
    prep(32'd3);
    wr(5'h08, 32'h3);
    wait_n(3);
    chk_reg("R5 zero reached", 5'h04, 0);
    chk_reg("R5 event", 5'h0C, 1);
    wait_n(1);
    chk_reg("R5 reload one tick later", 5'h04, 3);
    wait_n(3);
    chk_reg("R5 second expiry", 5'h04, 0);
  endtask

  task automatic t_prescale;
    prep(32'd2);
    wr(5'h08, 32'h201);
    chk_reg("R2 ctrl readback", 5'h08, 32'h201);
    wait_n(2);
    chk_reg("R3 no step before P+1", 5'h04, 2);
    wait_n(1);
    chk_reg("R3 step at P+1", 5'h04, 1);
    wait_n(3);
    chk_reg("R3 zero after 2*(P+1)", 5'h04, 0);
    chk_reg("R3 event", 5'h0C, 1);
  endtask

  task automatic t_load_zero;
    prep(32'd10);
    wr(5'h08, 32'h1);
    wait_n(2);
    chk_reg("R7 running", 5'h04, 8);
    wr(5'h00, 32'h0);
    chk_reg("R7 count cleared", 5'h04, 0);
    wait_n(5);
    chk_reg("R7 no event", 5'h0C, 0);
    chk_reg("R7 stays zero", 5'h04, 0);
  endtask

  task automatic t_cnt_zero;
    prep(32'd8);
    wr(5'h08, 32'h3);
    wait_n(2);
    chk_reg("R8 periodic running", 5'h04, 6);
    wr(5'h04, 32'h0);
    chk_reg("R8 periodic reload", 5'h04, 8);
    wait_n(1);
    chk_reg("R8 keeps counting", 5'h04, 7);
    chk_reg("R8 no event", 5'h0C, 0);
    wr(5'h08, 32'h0);
    wait_n(5);
    chk_reg("R11 frozen", 5'h04, 7);
    prep(32'd8);
    wr(5'h08, 32'h1);
    wait_n(2);
    wr(5'h04, 32'h0);
    wait_n(4);
    chk_reg("R8 one-shot stop", 5'h04, 0);
    chk_reg("R8 one-shot no event", 5'h0C, 0);
  endtask

  task automatic t_zero_load;
    prep(32'd0);
    wr(5'h08, 32'h3);
    wr(5'h04, 32'd2);
    wait_n(2);
    chk_reg("R10 count zero", 5'h04, 0);
    chk_reg("R10 one event", 5'h0C, 1);
    wr(5'h0C, 32'h1);
    wait_n(3);
    chk_reg("R10 no repeat P0", 5'h0C, 0);
    prep(32'd0);
    wr(5'h08, 32'h103);
    wait_n(1);
    chk_reg("R10 not yet", 5'h0C, 0);
    wait_n(1);
    chk_reg("R10 event P1", 5'h0C, 1);
    wr(5'h0C, 32'h1);
    chk_reg("R10 cleared", 5'h0C, 0);
    wait_n(1);
    chk_reg("R10 repeats P1", 5'h0C, 1);
  endtask

  task automatic t_ctl_reload;
    prep(32'd4);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h3);
    chk_reg("R9 reload on enable", 5'h04, 4);
    wait_n(1);
    chk_reg("R9 counting", 5'h04, 3);
  endtask

  task automatic t_unmapped;
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h1234);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    chk_reg("R2 unmapped read 0x10", 5'h10, 0);
    chk_reg("R2 unmapped read 0x1C", 5'h1C, 0);
    chk_reg("R2 load unchanged", 5'h00, 32'h1234);
    wr(5'h08, 32'hFFFF_FFFF);
    chk_reg("R2 ctrl reserved zero", 5'h08, 32'h0000_FF07);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_irq();
    t_periodic();
    t_prescale();
    t_load_zero();
    t_cnt_zero();
    t_zero_load();
    t_ctl_reload();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule